// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may go ahead under page-level protection. It takes the kind of access (read, write or instruction fetch), the current privilege level and the write-protect control bit. It also takes the present, user, writable and no-execute bits of both the directory entry and the table entry that map the page. It combines the two levels into one effective permission and answers with either an allow or a page fault that carries an error code.

A request is presented with a one-cycle strobe. The verdict appears on registered outputs exactly one clock later. A new request may be issued on every cycle, so a page-walk or translation pipeline can feed it at full rate. The walk itself, translation caching and the updating of accessed and dirty bits are handled elsewhere.

Top module: `pg_perm_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and a request accepted on every cycle gets a verdict on every following cycle.
- R2: When `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_fault` is high. When `rsp_valid` is low, both are low. `rsp_code` is zero whenever `rsp_fault` is low.
- R3: If the present bit of either level is 0, the access faults with code bit 0 clear, whatever the other bits say.
- R4: At privilege level 3 (user), an access faults if the user bit of either level is 0. Levels 0, 1 and 2 (supervisor) are not restricted by the user bits.
- R5: A user-mode write faults if the writable bit of either level is 0. A user-mode read of such a page is allowed.
- R6: A supervisor-mode write to a page whose writable bit is 0 at either level is allowed when `wp_en` is 0 and faults when `wp_en` is 1.
- R7: An instruction fetch faults at any privilege level if the no-execute bit of either level is 1. Reads and writes ignore the no-execute bits.
- R8: The fault code has bit 0 = page present (1 for a protection fault), bit 1 = the access was a write, bit 2 = the access came from level 3, and bit 4 = the access was a fetch. Bit 3 is always 0.
- R9: `req_kind` encodes 2'b00 read, 2'b01 write and 2'b10 fetch. The value 2'b11 is handled exactly as a read.
- R10: While `rst_n` is low, `rsp_valid`, `rsp_allow`, `rsp_fault` and `rsp_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one per access |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| req_pl | input | PL_W | Current privilege level |
| wp_en | input | 1 | Write-protect control: supervisor writes obey read-only pages |
| dir_present | input | 1 | Directory entry present bit |
| dir_user | input | 1 | Directory entry user-accessible bit |
| dir_write | input | 1 | Directory entry writable bit |
| dir_nx | input | 1 | Directory entry no-execute bit |
| tbl_present | input | 1 | Table entry present bit |
| tbl_user | input | 1 | Table entry user-accessible bit |
| tbl_write | input | 1 | Table entry writable bit |
| tbl_nx | input | 1 | Table entry no-execute bit |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access denied, page fault |
| rsp_code | output | 5 | Page fault error code |

## Verification
Every verdict, including the code, is due on the clock edge right after the request strobe. No result is due in the request cycle itself. The bench drives each request on a falling edge and reads the verdict on the next falling edge, half a cycle after the register has loaded. In the back-to-back test, the bench reads the previous verdict on that same falling edge and then drives the next request, so each verdict is compared in the only cycle in which it is shown. The bound properties use the same one-edge offset, written as implication to the next cycle.

// File: rtl/pg_perm_check.sv
module pg_perm_check #(
  parameter int PL_W    = 2,
  parameter int USER_PL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [PL_W-1:0] req_pl,
  input  logic            wp_en,
  input  logic            dir_present,
  input  logic            dir_user,
  input  logic            dir_write,
  input  logic            dir_nx,
  input  logic            tbl_present,
  input  logic            tbl_user,
  input  logic            tbl_write,
  input  logic            tbl_nx,
  output logic            rsp_valid,
  output logic            rsp_allow,
  output logic            rsp_fault,
  output logic [4:0]      rsp_code
);

  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  logic is_write, is_fetch, is_user;
  logic eff_present, eff_user, eff_write, eff_nx;
  logic deny;
  logic [4:0] code_nxt;

  assign is_write = (req_kind == KIND_WRITE);
  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_user  = (req_pl == PL_W'(USER_PL));

  assign eff_present = dir_present & tbl_present;
  assign eff_user    = dir_user & tbl_user;
  assign eff_write   = dir_write & tbl_write;
  assign eff_nx      = dir_nx | tbl_nx;

  assign deny = ~eff_present
              | (is_user & ~eff_user)
              | (is_write & ~eff_write & (is_user | wp_en))
              | (is_fetch & eff_nx);

  assign code_nxt = {is_fetch, 1'b0, is_user, is_write, eff_present};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid & ~deny;
      rsp_fault <= req_valid & deny;
      rsp_code  <= (req_valid & deny) ? code_nxt : '0;
    end
  end

endmodule

module pg_perm_check_sva #(
  parameter int PL_W    = 2,
  parameter int USER_PL = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [PL_W-1:0] req_pl,
  input logic            wp_en,
  input logic            dir_present,
  input logic            dir_user,
  input logic            dir_write,
  input logic            dir_nx,
  input logic            tbl_present,
  input logic            tbl_user,
  input logic            tbl_write,
  input logic            tbl_nx,
  input logic            rsp_valid,
  input logic            rsp_allow,
  input logic            rsp_fault,
  input logic [4:0]      rsp_code
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_allow, rsp_fault}) == 1); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_allow && !rsp_fault); // R2
  AST_CODE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> rsp_code == 5'd0); // R2
  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !(dir_present && tbl_present) |=> rsp_fault && !rsp_code[0]); // R3
  AST_USER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_pl == PL_W'(USER_PL) && !(dir_user && tbl_user)
    |=> rsp_fault && rsp_code[2]); // R4
  AST_SUP_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b01 && req_pl != PL_W'(USER_PL) && !wp_en
    && dir_present && tbl_present |=> rsp_allow); // R6
  AST_NX_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 2'b10 && (dir_nx || tbl_nx)
    |=> rsp_fault && rsp_code[4]); // R7
  AST_CODE_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_code[3]); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !rsp_valid && !rsp_allow && !rsp_fault && rsp_code == 5'd0); // R10

endmodule

bind pg_perm_check pg_perm_check_sva #(.PL_W(PL_W), .USER_PL(USER_PL)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_pl(req_pl), .wp_en(wp_en), .dir_present(dir_present), .dir_user(dir_user),
  .dir_write(dir_write), .dir_nx(dir_nx), .tbl_present(tbl_present),
  .tbl_user(tbl_user), .tbl_write(tbl_write), .tbl_nx(tbl_nx),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
  .rsp_code(rsp_code)
);

// File: tb/pg_perm_check_tb_top.sv
module pg_perm_check_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [1:0] req_pl = 2'b00;
  logic wp_en = 1'b0;
  logic [3:0] dir_bits = 4'b0000;
  logic [3:0] tbl_bits = 4'b0000;
  logic rsp_valid, rsp_allow, rsp_fault;
  logic [4:0] rsp_code;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pg_perm_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_pl(req_pl), .wp_en(wp_en),
    .dir_present(dir_bits[3]), .dir_user(dir_bits[2]),
    .dir_write(dir_bits[1]), .dir_nx(dir_bits[0]),
    .tbl_present(tbl_bits[3]), .tbl_user(tbl_bits[2]),
    .tbl_write(tbl_bits[1]), .tbl_nx(tbl_bits[0]),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code)
  );

  // {kind, pl, wp, dir P U W NX, tbl P U W NX, fault, code}
  localparam int NV = 22;
  localparam logic [18:0] VEC [NV] = '{
    19'b00_00_0_1110_1110_0_00000,
    19'b01_11_0_1110_1110_0_00000,
    19'b10_11_0_1110_1110_0_00000,
    19'b00_11_0_1010_1110_1_00101,
    19'b00_11_0_1110_1010_1_00101,
    19'b00_00_0_1010_1010_0_00000,
    19'b01_11_0_1100_1110_1_00111,
    19'b01_11_0_1110_1100_1_00111,
    19'b00_11_0_1100_1100_0_00000,
    19'b01_01_0_1100_1110_0_00000,
    19'b01_01_1_1100_1110_1_00011,
    19'b01_10_1_1110_1100_1_00011,
    19'b01_00_1_1110_1110_0_00000,
    19'b10_00_0_1111_1110_1_10001,
    19'b10_11_0_1110_1111_1_10101,
    19'b00_11_0_1111_1111_0_00000,
    19'b00_00_0_0110_1110_1_00000,
    19'b01_11_0_1110_0110_1_00110,
    19'b10_10_0_0111_1110_1_10000,
    19'b11_11_0_1110_1100_0_00000,
    19'b11_11_0_1010_1110_1_00101,
    19'b01_11_1_1110_1110_0_00000
  };

  function automatic string tag_of(int i);
    case (i)
      3, 4, 5:     return "R4";
      6, 7, 8:     return "R5";
      9, 10, 11, 12: return "R6";
      13, 14, 15:  return "R7";
      16, 17, 18:  return "R3";
      19, 20:      return "R9";
      default:     return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid/allow/fault/code=%b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic [18:0] v);
    req_kind  = v[18:17];
    req_pl    = v[16:15];
    wp_en     = v[14];
    dir_bits  = v[13:10];
    tbl_bits  = v[9:6];
    req_valid = 1'b1;
  endtask

  function automatic logic [7:0] expect_of(logic [18:0] v);
    return {1'b1, ~v[5], v[5], v[4:0]};
  endfunction

  initial begin
    // R10: reset holds outputs low even with a request pending
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check("R10", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, 8'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, one request at a time; R8 code layout checked on every vector
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag_of(i), {rsp_valid, rsp_allow, rsp_fault, rsp_code}, expect_of(VEC[i]));
    end

    // R2: idle cycle after a faulting request shows nothing
    @(negedge clk);
    check("R2", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, 8'd0);

    // R1: back-to-back requests, each verdict in its own cycle
    drive(VEC[3]);
    @(negedge clk);
    check("R1", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, expect_of(VEC[3]));
    drive(VEC[0]);
    @(negedge clk);
    check("R1", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, expect_of(VEC[0]));
    drive(VEC[13]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, expect_of(VEC[13]));
    @(negedge clk);
    check("R1", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, 8'd0);

    // R7: no-execute has no effect on a supervisor write
    drive(19'b01_00_0_1111_1111_0_00000);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, 8'b1100_0000);

    // R10: reset in mid-stream clears a pending verdict
    drive(VEC[4]);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #1 check("R10", {rsp_valid, rsp_allow, rsp_fault, rsp_code}, 8'd0);
    req_valid = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule